// File: doc/BRIEF.md
# AXI ID Filtered Traffic Monitor

This block sits in front of three event counters of a memory-traffic performance monitor. Three strobe streams come in: read transactions, write transactions and read-data beats. Each strobe carries an 18-bit AXI ID. A strobe turns into an event pulse on its own output only when the filter for its traffic class is switched on and the incoming ID agrees with a programmed reference ID on every bit the programmed mask selects.

Software sets the filter through two 32-bit registers on a simple write/read port. The control word holds the three per-class switches and the mask. The match word holds the reference ID. The three pulse outputs feed the event inputs of the downstream counters. That counter bank is not part of this block, and neither is any checking of the AXI protocol.

Top module: `idfilt_mon`

## Requirements
- R1: A synchronous active-low reset clears both registers to zero, so both read back as 0. All three pulse outputs are low in the cycle after a reset edge.
- R2: The control word is at byte offset 0x00. Bit 31 switches on the read-transaction filter, bit 30 the write-transaction filter and bit 29 the read-beat filter. Bits 17:0 are the ID mask. Bits 28:18 read back as 0 whatever was written.
- R3: The match word is at byte offset 0x04. Bits 17:0 hold the reference ID. Bits 31:18 read back as 0.
- R4: A write to any offset other than 0x00 and 0x04 changes no register. A read of any other offset returns 0.
- R5: An ID matches when (incoming ID AND mask) equals (reference ID AND mask). Bits outside the mask play no part in the result.
- R6: With a mask of all zeros, every ID matches.
- R7: While a class's switch is 0, that class's output stays low whatever its strobe and ID are.
- R8: Each output is registered. It is high in exactly the cycle after a qualifying strobe cycle, so back-to-back strobes give back-to-back pulses. A cycle with no strobe gives no pulse.
- R9: The classes are independent. Each output depends only on its own strobe, its own ID and its own switch, plus the shared mask and reference.
- R10: A register write takes effect for strobes from the following cycle on. A strobe in the same cycle as the write is judged against the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| rd_txn_vld | input | 1 | Read-transaction strobe |
| rd_txn_id | input | 18 | AXI ID of the read transaction |
| wr_txn_vld | input | 1 | Write-transaction strobe |
| wr_txn_id | input | 18 | AXI ID of the write transaction |
| rd_beat_vld | input | 1 | Read-data-beat strobe |
| rd_beat_id | input | 18 | AXI ID of the read beat |
| rd_txn_hit | output | 1 | Filtered read-transaction event pulse |
| wr_txn_hit | output | 1 | Filtered write-transaction event pulse |
| rd_beat_hit | output | 1 | Filtered read-beat event pulse |

## Verification
The hardest case to reach from the ports is a strobe in the very cycle the control word is rewritten. The old and new settings must disagree about that ID, and the pulse one cycle later has to follow the old ones. The stimulus gets there by first programming a zero mask, which accepts every ID. It then writes a full mask while strobing an ID one bit away from the reference, and strobes that same ID again in the next cycle, when it must be rejected. Besides this case, the bench sweeps the low four ID bits and one high bit under several masks, and covers all eight combinations of the class switches.

// File: rtl/idfilt_pkg.sv
// Shared constants for the AXI ID filter stage.
// Assumes byte-addressed 32-bit registers and three traffic classes.
package idfilt_pkg;
    localparam int ID_W   = 18;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int N_CLS  = 3;

    // Class index; the switch for class k sits at bit DATA_W-1-k.
    typedef enum logic [1:0] {
        CLS_RD_TXN  = 2'd0,
        CLS_WR_TXN  = 2'd1,
        CLS_RD_BEAT = 2'd2
    } cls_e;

    localparam logic [ADDR_W-1:0] CTRL_OFS  = 8'h00;
    localparam logic [ADDR_W-1:0] MATCH_OFS = 8'h04;
endpackage

// File: rtl/idfilt_regs.sv
// Holds the control word (class switches and mask) and the match word (reference ID).
// Assumes one write per cycle and full-word writes. Unused bits are never stored.
module idfilt_regs #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int ID_W   = 18,
    parameter int N_CLS  = 3,
    parameter logic [ADDR_W-1:0] CTRL_OFS  = '0,
    parameter logic [ADDR_W-1:0] MATCH_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [N_CLS-1:0]  en_o,
    output logic [ID_W-1:0]   mask_o,
    output logic [ID_W-1:0]   cmp_o
);
    localparam logic [DATA_W-1:0] ID_KEEP   = {{(DATA_W-ID_W){1'b0}}, {ID_W{1'b1}}};
    localparam logic [DATA_W-1:0] EN_KEEP   = {{N_CLS{1'b1}}, {(DATA_W-N_CLS){1'b0}}};
    localparam logic [DATA_W-1:0] CTRL_KEEP = EN_KEEP | ID_KEEP;

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] match_q;

    // Register update: decode the offset and keep only the implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            match_q <= '0;
        end else if (wr_en) begin
            if (addr == CTRL_OFS) begin
                ctrl_q <= wdata & CTRL_KEEP;
            end else if (addr == MATCH_OFS) begin
                match_q <= wdata & ID_KEEP;
            end
        end
    end

    // Read mux: return the addressed word, or zero for unmapped offsets.
    always_comb begin
        rdata = '0;
        if (addr == CTRL_OFS) begin
            rdata = ctrl_q;
        end else if (addr == MATCH_OFS) begin
            rdata = match_q;
        end
    end

    // Field slicing: one switch per class, counted down from the top bit.
    for (genvar k = 0; k < N_CLS; k++) begin : g_en
        assign en_o[k] = ctrl_q[DATA_W-1-k];
    end

    assign mask_o = ctrl_q[ID_W-1:0];
    assign cmp_o  = match_q[ID_W-1:0];
endmodule

// File: rtl/idfilt_match.sv
// Masked ID comparator. Purely combinational.
// Assumes a mask bit of 1 means "this bit must agree".
module idfilt_match #(
    parameter int ID_W = 18
) (
    input  logic [ID_W-1:0] id_i,
    input  logic [ID_W-1:0] cmp_i,
    input  logic [ID_W-1:0] mask_i,
    output logic            hit_o
);
    logic [ID_W-1:0] diff;

    // Compare: a masked bit that differs blocks the match.
    always_comb begin
        diff  = (id_i ^ cmp_i) & mask_i;
        hit_o = (diff == '0);
    end
endmodule

// File: rtl/idfilt_lane.sv
// One traffic class: gates its strobe with its switch and the masked match,
// then registers the result into a one-cycle event pulse.
// Assumes the strobe is high for one cycle per event.
module idfilt_lane #(
    parameter int ID_W = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            vld_i,
    input  logic [ID_W-1:0] id_i,
    input  logic [ID_W-1:0] cmp_i,
    input  logic [ID_W-1:0] mask_i,
    output logic            ev_o
);
    logic match;
    logic ev_q;

    idfilt_match #(.ID_W(ID_W)) u_match (
        .id_i   (id_i),
        .cmp_i  (cmp_i),
        .mask_i (mask_i),
        .hit_o  (match)
    );

    // Pulse register: one output cycle for each qualifying strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= 1'b0;
        end else begin
            ev_q <= vld_i & en_i & match;
        end
    end

    assign ev_o = ev_q;
endmodule

// File: rtl/idfilt_mon.sv
// AXI ID filter stage in front of three event counters.
// Each class has its own strobe and ID, and shares the mask and reference with the others.
// Outputs are registered, so each pulse comes one cycle after its strobe.
module idfilt_mon
    import idfilt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rd_txn_vld,
    input  logic [ID_W-1:0]   rd_txn_id,
    input  logic              wr_txn_vld,
    input  logic [ID_W-1:0]   wr_txn_id,
    input  logic              rd_beat_vld,
    input  logic [ID_W-1:0]   rd_beat_id,
    output logic              rd_txn_hit,
    output logic              wr_txn_hit,
    output logic              rd_beat_hit
);
    logic [N_CLS-1:0]           en_q;
    logic [ID_W-1:0]            mask_q;
    logic [ID_W-1:0]            cmp_q;
    logic [N_CLS-1:0]           vld_v;
    logic [N_CLS-1:0][ID_W-1:0] id_v;
    logic [N_CLS-1:0]           hit_v;

    idfilt_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .ID_W      (ID_W),
        .N_CLS     (N_CLS),
        .CTRL_OFS  (CTRL_OFS),
        .MATCH_OFS (MATCH_OFS)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .en_o   (en_q),
        .mask_o (mask_q),
        .cmp_o  (cmp_q)
    );

    // Gather the class inputs into vectors indexed by class.
    always_comb begin
        vld_v[CLS_RD_TXN]  = rd_txn_vld;
        vld_v[CLS_WR_TXN]  = wr_txn_vld;
        vld_v[CLS_RD_BEAT] = rd_beat_vld;
        id_v[CLS_RD_TXN]   = rd_txn_id;
        id_v[CLS_WR_TXN]   = wr_txn_id;
        id_v[CLS_RD_BEAT]  = rd_beat_id;
    end

    for (genvar k = 0; k < N_CLS; k++) begin : g_lane
        idfilt_lane #(.ID_W(ID_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (en_q[k]),
            .vld_i  (vld_v[k]),
            .id_i   (id_v[k]),
            .cmp_i  (cmp_q),
            .mask_i (mask_q),
            .ev_o   (hit_v[k])
        );
    end

    assign rd_txn_hit  = hit_v[CLS_RD_TXN];
    assign wr_txn_hit  = hit_v[CLS_WR_TXN];
    assign rd_beat_hit = hit_v[CLS_RD_BEAT];
endmodule

// File: rtl/idfilt_mon_chk.sv
// Property checker for idfilt_mon, attached with the bind below.
// Assumes the register map and the one-cycle output latency in the brief.
module idfilt_mon_chk
    import idfilt_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic [ADDR_W-1:0]          reg_addr,
    input logic [DATA_W-1:0]          reg_rdata,
    input logic [N_CLS-1:0]           en_q,
    input logic [ID_W-1:0]            mask_q,
    input logic [ID_W-1:0]            cmp_q,
    input logic [N_CLS-1:0]           vld_v,
    input logic [N_CLS-1:0][ID_W-1:0] id_v,
    input logic [N_CLS-1:0]           hit_v
);
    // R1: a reset edge leaves the outputs and the settings cleared.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (hit_v == '0 && en_q == '0 && mask_q == '0 && cmp_q == '0));

    // R2, R3: unimplemented upper bits never read back as 1.
    p_ctrl_gap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == CTRL_OFS) |-> (reg_rdata[DATA_W-N_CLS-1:ID_W] == '0));
    p_match_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == MATCH_OFS) |-> (reg_rdata[DATA_W-1:ID_W] == '0));

    // R4: unmapped offsets read as zero.
    p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != CTRL_OFS && reg_addr != MATCH_OFS) |-> (reg_rdata == '0));

    for (genvar k = 0; k < N_CLS; k++) begin : g_cls
        // R5: a masked match with the switch on yields a pulse next cycle.
        p_match_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_v[k] && en_q[k] && (((id_v[k] ^ cmp_q) & mask_q) == '0)) |=> hit_v[k]);
        // R5: a masked mismatch yields no pulse.
        p_mismatch_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (((id_v[k] ^ cmp_q) & mask_q) != '0) |=> !hit_v[k]);
        // R7: a class switched off stays silent.
        p_off_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q[k] |=> !hit_v[k]);
        // R8: no strobe, no pulse.
        p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !vld_v[k] |=> !hit_v[k]);
    end
endmodule

bind idfilt_mon idfilt_mon_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .cmp_q     (cmp_q),
    .vld_v     (vld_v),
    .id_v      (id_v),
    .hit_v     (hit_v)
);

// File: tb/sim_idfilt_mon.sv
`timescale 1ns/1ps
module sim_idfilt_mon;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rd_txn_vld = 1'b0, wr_txn_vld = 1'b0, rd_beat_vld = 1'b0;
    logic [17:0] rd_txn_id = '0, wr_txn_id = '0, rd_beat_id = '0;
    logic        rd_txn_hit, wr_txn_hit, rd_beat_hit;

    int    n_total = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    logic [31:0] m_ctrl = '0;
    logic [31:0] m_match = '0;
    logic [2:0]  exp_hit = '0;
    string       pend_tag = "R1";

    always #2 clk = ~clk;

    idfilt_mon u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_txn_vld(rd_txn_vld), .rd_txn_id(rd_txn_id),
        .wr_txn_vld(wr_txn_vld), .wr_txn_id(wr_txn_id),
        .rd_beat_vld(rd_beat_vld), .rd_beat_id(rd_beat_id),
        .rd_txn_hit(rd_txn_hit), .wr_txn_hit(wr_txn_hit), .rd_beat_hit(rd_beat_hit)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_hits();
        logic [2:0] got;
        got = {rd_beat_hit, wr_txn_hit, rd_txn_hit};
        chk(got === exp_hit, pend_tag, {29'd0, got}, {29'd0, exp_hit});
    endtask

    function automatic bit model_hit(input int k, input logic v, input logic [17:0] id);
        logic [17:0] msk;
        msk = m_ctrl[17:0];
        return v && m_ctrl[31-k] && (((id ^ m_match[17:0]) & msk) == 18'd0);
    endfunction

    // One cycle: check the previous cycle's pulses, then drive new stimulus.
    task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                       input logic [2:0] v, input logic [17:0] i0, input logic [17:0] i1,
                       input logic [17:0] i2, input string tag);
        @(negedge clk);
        check_hits();
        reg_wr_en = we; reg_addr = a; reg_wdata = d;
        rd_txn_vld = v[0]; wr_txn_vld = v[1]; rd_beat_vld = v[2];
        rd_txn_id = i0; wr_txn_id = i1; rd_beat_id = i2;
        exp_hit[0] = model_hit(0, v[0], i0);
        exp_hit[1] = model_hit(1, v[1], i1);
        exp_hit[2] = model_hit(2, v[2], i2);
        pend_tag = tag;
        if (we) begin
            if (a == 8'h00) m_ctrl = d & 32'hE003_FFFF;
            else if (a == 8'h04) m_match = d & 32'h0003_FFFF;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, a, d, 3'b000, '0, '0, '0, tag);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        check_hits();
        reg_wr_en = 1'b0; reg_addr = a;
        rd_txn_vld = 1'b0; wr_txn_vld = 1'b0; rd_beat_vld = 1'b0;
        exp_hit = '0;
        pend_tag = tag;
        #1;
        chk(reg_rdata === e, tag, reg_rdata, e);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        logic [17:0] base;
        logic [17:0] msk;
        logic [17:0] id;
        logic [2:0]  v;
        base = 18'h2A5A0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(8'h00, 32'h0, "R1 ctrl after reset");
        rd(8'h04, 32'h0, "R1 match after reset");
        // R2, R3, R4: register map
        wr(8'h00, 32'hFFFF_FFFF, "R2");
        rd(8'h00, 32'hE003_FFFF, "R2 ctrl readback");
        wr(8'h04, 32'hFFFF_FFFF, "R3");
        rd(8'h04, 32'h0003_FFFF, "R3 match readback");
        wr(8'h08, 32'h1234_5678, "R4");
        wr(8'h01, 32'h0000_0000, "R4");
        rd(8'h08, 32'h0, "R4 unmapped read");
        rd(8'h00, 32'hE003_FFFF, "R4 ctrl untouched");
        rd(8'h04, 32'h0003_FFFF, "R4 match untouched");
        // R5, R6, R8, R9: masked-match sweep
        wr(8'h04, {14'd0, base}, "R3");
        for (int m = 0; m < 5; m++) begin
            case (m)
                0: msk = 18'h00000;
                1: msk = 18'h0000F;
                2: msk = 18'h00005;
                3: msk = 18'h0000A;
                default: msk = 18'h3FFFF;
            endcase
            wr(8'h00, 32'hE000_0000 | {14'd0, msk}, "R2");
            for (int j = 0; j < 32; j++) begin
                id = {base[17] ^ j[4], base[16:4], j[3:0]};
                v = (j % 3 == 2) ? 3'b000 : ((j % 3 == 1) ? 3'b101 : 3'b111);
                cyc(1'b0, 8'h00, '0, v, id, id ^ 18'h1, id ^ 18'h2,
                    (m == 0) ? "R6 R8 R9" : "R5 R8 R9");
            end
        end
        // R7: every switch combination with a matching ID on all classes
        for (int e = 0; e < 8; e++) begin
            wr(8'h00, {e[0], e[1], e[2], 11'd0, 18'h3FFFF}, "R2");
            cyc(1'b0, 8'h00, '0, 3'b111, base, base, base, "R7");
            cyc(1'b0, 8'h00, '0, 3'b111, base ^ 18'h8, base, base ^ 18'h8, "R7 R9");
        end
        // R10: strobe in the write cycle uses the old settings
        wr(8'h00, 32'hE000_0000, "R6");
        cyc(1'b1, 8'h00, 32'hE003_FFFF, 3'b111, base ^ 18'h1, base ^ 18'h1, base ^ 18'h1, "R10 old");
        cyc(1'b0, 8'h00, '0, 3'b111, base ^ 18'h1, base ^ 18'h1, base ^ 18'h1, "R10 new");
        cyc(1'b1, 8'h04, {14'd0, base ^ 18'h1}, 3'b111, base ^ 18'h1, base, base, "R10 old");
        cyc(1'b0, 8'h00, '0, 3'b111, base ^ 18'h1, base, base ^ 18'h1, "R10 new");
        // R1: reset in mid-run clears registers and pulses
        cyc(1'b0, 8'h00, '0, 3'b111, base ^ 18'h1, base ^ 18'h1, base ^ 18'h1, "R8");
        @(negedge clk);
        check_hits();
        rst_n = 1'b0;
        m_ctrl = '0; m_match = '0;
        exp_hit = '0; pend_tag = "R1 pulses after reset";
        @(negedge clk);
        rst_n = 1'b1;
        rd(8'h00, 32'h0, "R1 ctrl after mid reset");
        rd(8'h04, 32'h0, "R1 match after mid reset");
        cyc(1'b0, 8'h00, '0, 3'b111, base, base, base, "R7 after reset");
        cyc(1'b0, 8'h00, '0, 3'b000, '0, '0, '0, "R8");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule